// File: doc/BRIEF.md
# Chainable SSI Encoder Slave

This block is the serial read-out side of a five-track absolute encoder. It sits behind the track comparators and lets a synchronous-serial master read the track word over a clock line that idles high. Several instances can be daisy-chained. Each serial output feeds the next device's serial input, so one master reads every position word in turn.

The SSI clock and the upstream data are oversampled on a fast system clock. A counter measures how long the clock line has been quiet. The first falling edge after a quiet period latches the conditioned track word into the output shifter. Every later falling edge takes one upstream bit into the tail of the shifter, and every rising edge drives the head bit onto the serial output.

Two output formats are available. The first is Gray code, with an optional low-active illumination-error bit appended after the track bits. The second is the track word converted from Gray to binary. A direction input and an inversion input condition the track bits before any conversion.

Top module: `ssi_chain_enc`

## Requirements
- R1: After reset, and whenever IDLE_CYC system clock cycles pass without a rising or falling SSI clock edge, the block is idle and sdo_o is driven high. Before that limit is reached, sdo_o holds its last value.
- R2: A falling SSI clock edge that arrives while idle loads a new frame. A falling edge that arrives before the idle limit only shifts the existing frame, with no reload.
- R3: sdo_o changes only in response to a rising SSI clock edge or to the idle condition. The MSB of the loaded word appears on the first rising edge after the load, followed by the lower bits in descending order.
- R4: mode_i = 2'b11 selects Gray output. The five conditioned track bits are sent as they are, and the register is 5 bits long. The codes 2'b00 and 2'b01 behave the same as 2'b11.
- R5: mode_i = 2'b10 selects binary output. Output bit 4 equals conditioned bit 4, and each lower output bit i equals output bit i+1 XOR conditioned bit i.
- R6: In Gray mode with err_en_i = 1, a sixth bit equal to NOT lamp_err_i follows the LSB, so a lamp fault is sent as 0. The register is then 6 bits long.
- R7: In binary mode, err_en_i has no effect. The upstream bits taken in on the first two shifting falling edges after a load are replaced by 0.
- R8: When dir_ni = 0, track bit 4 (MSB) is inverted before any format conversion.
- R9: When inv_ni = 0, all five track bits are inverted before any format conversion. With both dir_ni and inv_ni at 0, every bit except the MSB ends up inverted.
- R10: Once the local word (and error bit, if present) has been sent, the bits received on sdi_i follow on sdo_o in the order they arrived. The upstream device's first bit therefore appears on the rising edge just after the local LSB.
- R11: track_i, mode_i, err_en_i, lamp_err_i, dir_ni and inv_ni are sampled only at the load edge. Changes to them during a frame do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock used to oversample the SSI lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SSI clock from the master, idles high |
| sdi_i | input | 1 | Serial data from the upstream device |
| sdo_o | output | 1 | Serial data toward the master or the downstream device |
| track_i | input | TRACKS | Gray-coded track comparator levels, bit TRACKS-1 is the MSB |
| mode_i | input | 2 | Output format select: 2'b10 binary, other codes Gray |
| err_en_i | input | 1 | Appends the error bit in Gray mode |
| lamp_err_i | input | 1 | Illumination fault flag, high when faulty |
| dir_ni | input | 1 | Low inverts the track MSB |
| inv_ni | input | 1 | Low inverts all track bits |

## Verification
Suppose the shift register loads or shifts at the wrong falling edge. The two-device frame then reaches the master offset by one position, and the error first shows on the rising edge after the local LSB, where the upstream MSB should appear. A wrong idle count shows up as a reload in place of a shift after a short pause, or as sdo_o failing to go high within a few cycles of the limit. A bad skip count in binary mode corrupts exactly the sixth and seventh bits of the chained frame. A wrong conditioning or conversion shows up within the first five bits after the load.

// File: rtl/ssi_chain_pkg.sv
package ssi_chain_pkg;

  typedef enum logic [1:0] {
    FMT_RSV0 = 2'b00,
    FMT_RSV1 = 2'b01,
    FMT_BIN  = 2'b10,
    FMT_GRAY = 2'b11
  } ser_fmt_e;

  function automatic logic fmt_is_bin(input logic [1:0] code);
    return ser_fmt_e'(code) == FMT_BIN;
  endfunction

endpackage

// File: rtl/ssi_line_sync.sv
module ssi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);

  // one extra stage on the clock path for edge detection
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] sdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk_i};
      sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
    end
  end

  assign rise_o = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign fall_o = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign sdi_o  = sdi_q[STAGES-1];

endmodule

// File: rtl/ssi_idle_timer.sv
module ssi_idle_timer #(
  parameter int IDLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic idle_o
);

  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

  logic [CW-1:0] cnt_q;

  // starts saturated so the first falling edge after reset loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= LIMIT;
    else if (edge_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = (cnt_q == LIMIT);

endmodule

// File: rtl/ssi_frame_build.sv
module ssi_frame_build
  import ssi_chain_pkg::*;
#(
  parameter int TRACKS = 5,
  localparam int REG_W = TRACKS + 1
) (
  input  logic [TRACKS-1:0] track_i,
  input  logic [1:0]        mode_i,
  input  logic              err_en_i,
  input  logic              lamp_err_i,
  input  logic              dir_ni,
  input  logic              inv_ni,
  output logic [REG_W-1:0]  frame_o,
  output logic              len6_o,
  output logic              bin_o
);

  logic [TRACKS-1:0] cond, conv;

  assign cond = track_i ^ {TRACKS{~inv_ni}} ^ {~dir_ni, {(TRACKS-1){1'b0}}};

  assign conv[TRACKS-1] = cond[TRACKS-1];
  for (genvar i = TRACKS - 2; i >= 0; i--) begin : g_g2b
    assign conv[i] = conv[i+1] ^ cond[i];
  end

  assign bin_o   = fmt_is_bin(mode_i);
  assign len6_o  = ~bin_o & err_en_i;
  assign frame_o = {bin_o ? conv : cond, len6_o & ~lamp_err_i};

endmodule

// File: rtl/ssi_shift_core.sv
module ssi_shift_core #(
  parameter int TRACKS = 5,
  localparam int REG_W = TRACKS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             idle_i,
  input  logic             sdi_i,
  input  logic [REG_W-1:0] frame_i,
  input  logic             len6_i,
  input  logic             bin_i,
  output logic             sdo_o,
  output logic [REG_W-1:0] sr_o,
  output logic             skip_o
);

  logic [REG_W-1:0] sr_q;
  logic             len6_q, bin_q, sdo_q;
  logic [1:0]       skip_q;
  logic             in_bit;

  assign skip_o = bin_q & (skip_q != 2'd2);
  assign in_bit = skip_o ? 1'b0 : sdi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      len6_q <= 1'b0;
      bin_q  <= 1'b0;
      skip_q <= 2'd2;
    end else if (fall_i) begin
      if (idle_i) begin
        sr_q   <= frame_i;
        len6_q <= len6_i;
        bin_q  <= bin_i;
        skip_q <= 2'd0;
      end else begin
        // short frames insert above the unused error slot
        if (len6_q) sr_q <= {sr_q[REG_W-2:0], in_bit};
        else        sr_q <= {sr_q[REG_W-2:1], in_bit, 1'b0};
        if (skip_q != 2'd2) skip_q <= skip_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sdo_q <= 1'b1;
    else if (rise_i)  sdo_q <= sr_q[REG_W-1];
    else if (idle_i)  sdo_q <= 1'b1;
  end

  assign sdo_o = sdo_q;
  assign sr_o  = sr_q;

endmodule

// File: rtl/ssi_chain_enc.sv
module ssi_chain_enc #(
  parameter int TRACKS      = 5,
  parameter int IDLE_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [TRACKS-1:0] track_i,
  input  logic [1:0]        mode_i,
  input  logic              err_en_i,
  input  logic              lamp_err_i,
  input  logic              dir_ni,
  input  logic              inv_ni
);

  localparam int REG_W = TRACKS + 1;

  logic             sclk_rise, sclk_fall, sdi_s, link_idle;
  logic [REG_W-1:0] frm_word, shift_q;
  logic             frm_len6, frm_bin, skip_act;

  ssi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall),
    .sdi_o  (sdi_s)
  );

  ssi_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (sclk_rise | sclk_fall),
    .idle_o (link_idle)
  );

  ssi_frame_build #(.TRACKS(TRACKS)) u_frame (
    .track_i    (track_i),
    .mode_i     (mode_i),
    .err_en_i   (err_en_i),
    .lamp_err_i (lamp_err_i),
    .dir_ni     (dir_ni),
    .inv_ni     (inv_ni),
    .frame_o    (frm_word),
    .len6_o     (frm_len6),
    .bin_o      (frm_bin)
  );

  ssi_shift_core #(.TRACKS(TRACKS)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (sclk_rise),
    .fall_i  (sclk_fall),
    .idle_i  (link_idle),
    .sdi_i   (sdi_s),
    .frame_i (frm_word),
    .len6_i  (frm_len6),
    .bin_i   (frm_bin),
    .sdo_o   (sdo_o),
    .sr_o    (shift_q),
    .skip_o  (skip_act)
  );

endmodule

// File: rtl/ssi_chain_enc_chk.sv
module ssi_chain_enc_chk #(
  parameter int TRACKS = 5,
  localparam int REG_W = TRACKS + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdo_o,
  input logic             lamp_err_i,
  input logic             rise_i,
  input logic             fall_i,
  input logic             idle_i,
  input logic             len6_i,
  input logic [REG_W-1:0] sr_i,
  input logic             skip_i
);

  // R1
  edge_clears_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i || fall_i) |=> !idle_i);

  // R1
  idle_drives_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !rise_i) |=> sdo_o);

  // R3
  sdo_moves_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(rise_i) || $past(idle_i)));

  // R6
  err_bit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && idle_i && len6_i) |=> (sr_i[0] == !$past(lamp_err_i)));

  // R7
  bin_skip_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !idle_i && skip_i) |=> !sr_i[1]);

endmodule

bind ssi_chain_enc ssi_chain_enc_chk #(.TRACKS(TRACKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sdo_o      (sdo_o),
  .lamp_err_i (lamp_err_i),
  .rise_i     (sclk_rise),
  .fall_i     (sclk_fall),
  .idle_i     (link_idle),
  .len6_i     (frm_len6),
  .sr_i       (shift_q),
  .skip_i     (skip_act)
);

// File: tb/ssi_chain_enc_test.sv
module ssi_chain_enc_test;

  localparam int IDLE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic up_sdo, dn_sdo;

  logic [4:0] up_trk = '0, dn_trk = '0;
  logic [1:0] up_mode = 2'b11, dn_mode = 2'b11;
  logic up_err_en = 0, dn_err_en = 0, up_lamp = 0, dn_lamp = 0;
  logic up_dir_n = 1, dn_dir_n = 1, up_inv_n = 1, dn_inv_n = 1;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_bits;
  int exp_n;

  always #2 clk = ~clk;

  ssi_chain_enc #(.IDLE_CYC(IDLE)) u_up (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(1'b0), .sdo_o(up_sdo),
    .track_i(up_trk), .mode_i(up_mode), .err_en_i(up_err_en), .lamp_err_i(up_lamp),
    .dir_ni(up_dir_n), .inv_ni(up_inv_n)
  );

  ssi_chain_enc #(.IDLE_CYC(IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(up_sdo), .sdo_o(dn_sdo),
    .track_i(dn_trk), .mode_i(dn_mode), .err_en_i(dn_err_en), .lamp_err_i(dn_lamp),
    .dir_ni(dn_dir_n), .inv_ni(dn_inv_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [4:0] t, input logic dir_n, input logic inv_n,
                                     input logic bin);
    logic [4:0] w, b;
    w = t;
    if (!inv_n) w = ~w;
    if (!dir_n) w[4] = ~w[4];
    b[4] = w[4];
    for (int i = 3; i >= 0; i--) b[i] = b[i+1] ^ w[i];
    return bin ? b : w;
  endfunction

  task automatic build_exp();
    logic dn_bin, up_bin;
    logic [4:0] dw, uw;
    logic [5:0] ub;
    int un;
    int k;
    dn_bin = (dn_mode == 2'b10);
    up_bin = (up_mode == 2'b10);
    dw = enc(dn_trk, dn_dir_n, dn_inv_n, dn_bin);
    uw = enc(up_trk, up_dir_n, up_inv_n, up_bin);
    exp_bits = '0;
    k = 0;
    for (int i = 4; i >= 0; i--) begin exp_bits[k] = dw[i]; k++; end
    if (!dn_bin && dn_err_en) begin exp_bits[k] = ~dn_lamp; k++; end
    un = 0;
    for (int i = 4; i >= 0; i--) begin ub[un] = uw[i]; un++; end
    if (!up_bin && up_err_en) begin ub[un] = ~up_lamp; un++; end
    for (int i = 0; i < un; i++) begin
      exp_bits[k] = (dn_bin && i < 2) ? 1'b0 : ub[i];
      k++;
    end
    exp_n = k;
  endtask

  task automatic run_frame(input string tag, input bit mid_change);
    logic [15:0] got;
    got = '0;
    build_exp();
    for (int k = 0; k < exp_n; k++) begin
      @(negedge clk) sclk = 1'b0;
      if (k == 0 && mid_change) begin
        repeat (6) @(negedge clk);
        dn_trk = ~dn_trk; dn_mode = 2'b10; dn_inv_n = ~dn_inv_n;
        dn_err_en = 1; dn_lamp = ~dn_lamp; dn_dir_n = ~dn_dir_n;
        repeat (2) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      got[k] = dn_sdo;
      repeat (2) @(negedge clk);
    end
    check(tag, got, exp_bits);
    repeat (IDLE + 36) @(negedge clk);
  endtask

  task automatic cfg(input logic [4:0] ut, input logic [1:0] um, input logic [4:0] dt,
                     input logic [1:0] dm);
    up_trk = ut; up_mode = um; dn_trk = dt; dn_mode = dm;
    up_err_en = 0; dn_err_en = 0; up_lamp = 0; dn_lamp = 0;
    up_dir_n = 1; dn_dir_n = 1; up_inv_n = 1; dn_inv_n = 1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset sdo high down", {15'd0, dn_sdo}, 16'd1);
    check("R1 reset sdo high up", {15'd0, up_sdo}, 16'd1);
  endtask

  task automatic t_gray();
    cfg(5'b01101, 2'b11, 5'b10110, 2'b11);
    run_frame("R4 R10 R3 gray chain A", 0);
    cfg(5'b11111, 2'b11, 5'b00001, 2'b11);
    run_frame("R4 R10 gray chain B", 0);
  endtask

  task automatic t_binary();
    cfg(5'b10011, 2'b11, 5'b11010, 2'b10);
    run_frame("R5 R7 binary down skips upstream", 0);
    cfg(5'b11011, 2'b10, 5'b01110, 2'b11);
    run_frame("R5 R10 binary upstream", 0);
  endtask

  task automatic t_err();
    cfg(5'b00110, 2'b11, 5'b11001, 2'b11);
    dn_err_en = 1; dn_lamp = 1; up_err_en = 1; up_lamp = 0;
    run_frame("R6 error bits both devices", 0);
    cfg(5'b01010, 2'b11, 5'b10101, 2'b10);
    dn_err_en = 1; dn_lamp = 1;
    run_frame("R7 binary ignores err_en", 0);
  endtask

  task automatic t_dirinv();
    cfg(5'b00111, 2'b11, 5'b01011, 2'b11);
    dn_dir_n = 0;
    run_frame("R8 direction flips MSB gray", 0);
    cfg(5'b00111, 2'b11, 5'b01011, 2'b11);
    dn_inv_n = 0;
    run_frame("R9 inversion gray", 0);
    cfg(5'b10001, 2'b11, 5'b01011, 2'b11);
    dn_inv_n = 0; dn_dir_n = 0; up_dir_n = 0;
    run_frame("R9 R8 both low all but MSB", 0);
    cfg(5'b00100, 2'b11, 5'b11100, 2'b10);
    dn_inv_n = 0; dn_dir_n = 0;
    run_frame("R8 R9 conditioning before binary", 0);
  endtask

  task automatic t_hold();
    cfg(5'b01001, 2'b11, 5'b10011, 2'b11);
    run_frame("R11 inputs changed mid frame", 1);
  endtask

  // downstream word 01011: MSB 0, next bit 1
  task automatic t_idle();
    cfg(5'b00000, 2'b11, 5'b01011, 2'b11);
    @(negedge clk) sclk = 1'b0;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 first bit is MSB", {15'd0, dn_sdo}, 16'd0);
    repeat (34) @(negedge clk);
    check("R1 holds before idle limit", {15'd0, dn_sdo}, 16'd0);
    repeat (50) @(negedge clk);
    check("R1 high after idle limit", {15'd0, dn_sdo}, 16'd1);
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 reload after idle", {15'd0, dn_sdo}, 16'd0);
    repeat (24) @(negedge clk);
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 short gap shifts", {15'd0, dn_sdo}, 16'd1);
    repeat (IDLE + 36) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_gray();
    t_binary();
    t_err();
    t_dirinv();
    t_hold();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule